// File: doc/BRIEF.md
# Host Interrupt Vector Controller

This block gathers interrupt causes from a network adapter and presents the most urgent one to host software as a 16-bit read-only status word. The word holds a 3-bit type code and an 8-bit vector. Both sit at fixed bit positions, so software can use the word directly as an offset into a jump table. A single level interrupt line goes toward the host bus.

Each of seven cause types has its own request strobe and a source index (a channel or flag number). The index is latched into a per-type pending bitmap. A fixed arbiter picks the winning type, and within that type the lowest pending index wins. The status word always shows the current winner, even while software is servicing a lower cause. A host write whose type field is nonzero masks the interrupt line. An acknowledge strobe from the command path does two things: it retires the cause shown at that moment and it clears the mask.

The request, write and acknowledge inputs are single-cycle strobes that are always accepted. The block has no back-pressure, so no ready signal exists.

Top module: `ivc_host_int`

## Requirements
- R1: Status word layout: bits 15:13 and 1:0 always read 0. Bits 12:5 carry the vector, zero-extended from the source index. Bits 4:2 carry the type code.
- R2: When no cause is pending, the status word is 0x0000 (type 000) and `host_irq` is low. This is also the state after reset.
- R3: Type codes are 001 tx end-of-frame, 010 statistics overflow, 011 rx end-of-frame, 100 software dummy, 101 tx end-of-channel, 110 adapter check / network status, 111 rx end-of-channel. Fixed priority, highest first: 110, 010, 111, 101, 011, 001, 100.
- R4: Within one type, the lowest pending index is shown. Under type 110, vector 0 means network status and any nonzero vector means adapter check.
- R5: A pulse on `req_stb[c-1]` with index `req_idx[(c-1)*IDX_W +: IDX_W]` makes that cause pending. The cause shows in the word on the next cycle, and `host_irq` rises in that cycle unless the line is masked.
- R6: A host write with a nonzero value in bits 4:2 holds `host_irq` low until an acknowledge. A write with zero in bits 4:2 has no effect. No write ever changes the status word.
- R7: An acknowledge clears the pending bit of the type and vector shown at that moment and clears the mask. On the next cycle the next cause appears, and `host_irq` is high if any cause remains.
- R8: While the line is masked, a newly arriving higher-priority cause replaces the shown one at once, and the line stays low.
- R9: If a request sets the same type and index that an acknowledge clears in the same cycle, the request wins and the cause stays pending.
- R10: Repeated requests for an already pending cause merge into one, so a single acknowledge retires it.
- R11: An acknowledge with nothing pending leaves the word at zero and the line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_stb | input | 7 | Request strobe per type; bit c-1 is type code c |
| req_idx | input | 7*IDX_W | Source index per type, slice c-1 for type code c |
| host_wr | input | 1 | Host write strobe to the status word |
| host_wdata | input | 16 | Host write data; only bits 4:2 matter |
| ack | input | 1 | Acknowledge strobe from the command path |
| status_word | output | 16 | Current highest-priority cause |
| host_irq | output | 1 | Level interrupt toward the host bus |

## Verification
The assertions assume that every strobe is a clean single-cycle pulse sampled at the clock edge. They also assume that each index is below NSRC, because an out-of-range index is dropped and would defeat the "request makes the word nonzero" property. Further, they assume that a host write and an acknowledge do not arrive in the same cycle. The stimulus keeps to these rules: each task drives its pulses on the falling edge, uses indices 0 to 7 with the default eight sources, and never overlaps a write with an acknowledge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NTYPES = 7;
  typedef logic [2:0] itype_t;

  localparam itype_t T_NONE   = 3'b000;
  localparam itype_t T_TXEOF  = 3'b001;
  localparam itype_t T_STAT   = 3'b010;
  localparam itype_t T_RXEOF  = 3'b011;
  localparam itype_t T_DUMMY  = 3'b100;
  localparam itype_t T_TXEOC  = 3'b101;
  localparam itype_t T_CHECK  = 3'b110;
  localparam itype_t T_RXEOC  = 3'b111;

  // rank 0 is the most urgent type
  function automatic itype_t code_at_rank(input int rank);
    case (rank)
      0: code_at_rank = T_CHECK;
      1: code_at_rank = T_STAT;
      2: code_at_rank = T_RXEOC;
      3: code_at_rank = T_TXEOC;
      4: code_at_rank = T_RXEOF;
      5: code_at_rank = T_TXEOF;
      6: code_at_rank = T_DUMMY;
      default: code_at_rank = T_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ivc_pend_bank.sv
module ivc_pend_bank #(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_stb,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NSRC-1:0]  pend
);
  logic [NSRC-1:0] pend_nx;

  always_comb begin
    pend_nx = pend;
    if (clr_stb && (int'(clr_idx) < NSRC)) pend_nx[clr_idx] = 1'b0;
    // a new event on the same bit outranks its retirement
    if (set_stb && (int'(set_idx) < NSRC)) pend_nx[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nx;
  end
endmodule

// File: rtl/ivc_first_set.sv
module ivc_first_set #(
  parameter int N  = 8,
  parameter int OW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [OW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = OW'(i);
      end
    end
  end
endmodule

// File: rtl/ivc_type_arb.sv
module ivc_type_arb
  import ivc_pkg::*;
(
  input  logic [NTYPES-1:0] any_pend, // bit c-1 is type code c
  output itype_t            sel_code
);
  always_comb begin
    sel_code = T_NONE;
    for (int r = NTYPES - 1; r >= 0; r--) begin
      if (any_pend[int'(code_at_rank(r)) - 1]) sel_code = code_at_rank(r);
    end
  end
endmodule

// File: rtl/ivc_mask_ctl.sv
module ivc_mask_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [2:0]  wr_type,
  input  logic        ack,
  output logic        masked
);
  always_ff @(posedge clk) begin
    if (!rst_n)                          masked <= 1'b0;
    else if (host_wr && wr_type != 3'b0) masked <= 1'b1;
    else if (ack)                        masked <= 1'b0;
  end
endmodule

// File: rtl/ivc_host_int.sv
module ivc_host_int
  import ivc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int VEC_W = 8,
  parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NTYPES-1:0]       req_stb,
  input  logic [NTYPES*IDX_W-1:0] req_idx,
  input  logic                    host_wr,
  input  logic [15:0]             host_wdata,
  input  logic                    ack,
  output logic [15:0]             status_word,
  output logic                    host_irq
);
  localparam int VEC_LSB  = 5;
  localparam int TYPE_LSB = 2;

  logic [NTYPES-1:0]       any_pend;
  logic [NTYPES*IDX_W-1:0] first_idx;
  itype_t                  sel_code;
  logic [IDX_W-1:0]        sel_idx;
  logic [VEC_W-1:0]        sel_vec;
  logic                    masked;

  ivc_type_arb u_arb (.any_pend(any_pend), .sel_code(sel_code));

  generate
    for (genvar g = 0; g < NTYPES; g++) begin : g_type
      logic [NSRC-1:0] pend;
      logic            clr;
      assign clr = ack && (int'(sel_code) == g + 1);

      ivc_pend_bank #(.NSRC(NSRC), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (req_stb[g]),
        .set_idx (req_idx[g*IDX_W +: IDX_W]),
        .clr_stb (clr),
        .clr_idx (first_idx[g*IDX_W +: IDX_W]),
        .pend    (pend)
      );

      ivc_first_set #(.N(NSRC), .OW(IDX_W)) u_first (
        .vec   (pend),
        .found (any_pend[g]),
        .idx   (first_idx[g*IDX_W +: IDX_W])
      );
    end
  endgenerate

  always_comb begin
    sel_idx = '0;
    for (int t = 0; t < NTYPES; t++)
      if (int'(sel_code) == t + 1) sel_idx = first_idx[t*IDX_W +: IDX_W];
    sel_vec = '0;
    sel_vec[IDX_W-1:0] = sel_idx;
  end

  ivc_mask_ctl u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_wr (host_wr),
    .wr_type (host_wdata[TYPE_LSB +: 3]),
    .ack     (ack),
    .masked  (masked)
  );

  always_comb begin
    status_word = '0;
    status_word[VEC_LSB +: VEC_W] = sel_vec;
    status_word[TYPE_LSB +: 3]    = sel_code;
  end

  assign host_irq = (|any_pend) && !masked;
endmodule

// File: rtl/ivc_host_int_chk.sv
module ivc_host_int_chk #(
  parameter int NT = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic [NT-1:0] req_stb,
  input logic        host_wr,
  input logic [15:0] host_wdata,
  input logic        ack,
  input logic [15:0] status_word,
  input logic        host_irq
);
  assert_zero_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[15:13] == 3'b0 && status_word[1:0] == 2'b0);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[4:2] == 3'b0 |-> !host_irq);

  assert_req_shows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_stb != '0 && !ack) |=> status_word[4:2] != 3'b0);

  assert_write_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_wdata[4:2] != 3'b0 && !ack) |=> !host_irq);

  assert_write_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && req_stb == '0 && !ack) |=> $stable(status_word));

  assert_ack_unmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !host_wr) |=> host_irq == (status_word[4:2] != 3'b0));
endmodule

bind ivc_host_int ivc_host_int_chk #(.NT(7)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .host_wr(host_wr),
  .host_wdata(host_wdata), .ack(ack), .status_word(status_word),
  .host_irq(host_irq)
);

// File: tb/test_ivc_host_int.sv
module test_ivc_host_int;
  localparam int IDX_W = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] req_stb = '0;
  logic [7*IDX_W-1:0] req_idx = '0;
  logic host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic ack = 1'b0;
  logic [15:0] status_word;
  logic host_irq;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ivc_host_int i_ivc_host_int (
    .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_idx(req_idx),
    .host_wr(host_wr), .host_wdata(host_wdata), .ack(ack),
    .status_word(status_word), .host_irq(host_irq)
  );

  function automatic logic [15:0] w(input int code, input int idx);
    return 16'((idx << 5) | (code << 2));
  endfunction

  task automatic check(input string req, input logic [15:0] exp_w, input logic exp_irq);
    n_chk++;
    if (status_word !== exp_w || host_irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: word=%h irq=%b expected word=%h irq=%b",
               req, status_word, host_irq, exp_w, exp_irq);
    end
  endtask

  // all strobes are driven on the falling edge for one cycle
  task automatic request(input int code, input int idx);
    req_stb[code-1] = 1'b1;
    req_idx[(code-1)*IDX_W +: IDX_W] = IDX_W'(idx);
    @(negedge clk);
    req_stb = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] d);
    host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic t_reset();
    check("R2 reset", 16'h0000, 1'b0);
  endtask

  task automatic t_single();
    request(1, 3);
    check("R5 R1 single request", w(1, 3), 1'b1);
    do_ack();
    check("R7 ack to idle", 16'h0000, 1'b0);
  endtask

  task automatic t_priority();
    int order[7] = '{6, 2, 7, 5, 3, 1, 4};
    for (int c = 1; c <= 7; c++) begin
      req_stb[c-1] = 1'b1;
      req_idx[(c-1)*IDX_W +: IDX_W] = 3'd2;
    end
    @(negedge clk);
    req_stb = '0;
    for (int k = 0; k < 7; k++) begin
      check("R3 priority order", w(order[k], 2), 1'b1);
      do_ack();
    end
    check("R7 drained", 16'h0000, 1'b0);
  endtask

  task automatic t_within();
    request(7, 5);
    request(7, 1);
    check("R4 lowest index", w(7, 1), 1'b1);
    do_ack();
    check("R7 next index", w(7, 5), 1'b1);
    do_ack();
    request(6, 4);
    request(6, 0);
    check("R4 network status vector 0", w(6, 0), 1'b1);
    do_ack();
    check("R4 adapter check nonzero", w(6, 4), 1'b1);
    do_ack();
  endtask

  task automatic t_mask();
    request(3, 0);
    do_write(16'hFFE3);
    check("R6 zero type write ignored", w(3, 0), 1'b1);
    do_write(16'h0004);
    check("R6 mask write", w(3, 0), 1'b0);
    do_write(16'h001C);
    check("R6 word unchanged by write", w(3, 0), 1'b0);
    request(6, 2);
    check("R8 higher cause while masked", w(6, 2), 1'b0);
    do_ack();
    check("R7 unmask and next cause", w(3, 0), 1'b1);
    do_ack();
    check("R7 idle", 16'h0000, 1'b0);
  endtask

  task automatic t_set_clear();
    request(1, 2);
    ack = 1'b1;
    req_stb[0] = 1'b1;
    req_idx[0 +: IDX_W] = 3'd2;
    @(negedge clk);
    ack = 1'b0; req_stb = '0;
    check("R9 set beats clear", w(1, 2), 1'b1);
    do_ack();
    check("R9 cleared afterwards", 16'h0000, 1'b0);
  endtask

  task automatic t_dup();
    request(5, 1);
    request(5, 1);
    do_ack();
    check("R10 duplicates merge", 16'h0000, 1'b0);
  endtask

  task automatic t_idle_ack();
    do_ack();
    check("R11 ack while idle", 16'h0000, 1'b0);
    request(4, 0);
    check("R11 dummy after idle ack", w(4, 0), 1'b1);
    do_ack();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_priority();
    t_within();
    t_mask();
    t_set_clear();
    t_dup();
    t_idle_ack();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule